// File: doc/BRIEF.md
# Circular Sector Buffer Pointer Manager

This block steers a circular word buffer that two parties share: a host transfer engine and a local processor. It holds three pointers: the host pointer, the disk (local) pointer and the stop pointer. All three wrap at a buffer size chosen from a power-of-two range. A small control word starts and stops host bursts, sets their direction, and reports when a burst has ended. The block then drives one shared RAM port with an address, an enable and a write strobe for every word that either side moves.

A host burst begins when the start bit is written. Each host word strobe moves one word at the host pointer and advances the pointer. The burst ends on the strobe whose incremented pointer lands on the stop pointer. Local accesses use the disk pointer, which can advance by itself after each access. When both sides want the RAM port in the same cycle, the host word goes first and the local access follows in the next free cycle.

Top module: `sbuf_ptr_mgr`

## Requirements
- R1: After reset the host and disk pointers read 0000h, the stop pointer reads 00FFh, the control readback reads 08h, and xfer_req and ram_en are low. Control bits: 0 start, 1 done (read-only), 2 direction, 3 RAM disable, 4 auto interrupt enable, 5 busy-on-done enable.
- R2: size_sel picks the wrap size: 000 and 001 give 32K words, 010 16K, 011 8K, 100 4K, 101 2K, 110 1K, 111 512. Pointer loads keep only the bits below the size, and every increment wraps to zero past the top word.
- R3: On a host word, ram_we equals the direction bit. Direction 0 reads the buffer toward the host, and direction 1 writes host data into the buffer.
- R4: A host word (host_xfer while a burst is active and the RAM is enabled) drives ram_en with ram_host_sel high and ram_addr equal to the host pointer. The host pointer then advances by one, modulo the size.
- R5: A burst ends on the host word whose incremented pointer equals the stop pointer. Start clears and done sets at that point, so a burst moves ((stop - first - 1) mod size) + 1 words. Equal pointers therefore move the whole buffer.
- R6: xfer_req is high exactly while start is set and done is clear. Writing start as 1 clears done. Writing start as 0 during a burst ends it without setting done.
- R7: While the RAM disable bit is 1, ram_en stays low, and host words and local accesses leave every pointer unchanged.
- R8: A local access puts the disk pointer on ram_addr with ram_we equal to lcl_wr. With auto_inc_en high the disk pointer advances by one modulo the size. With auto_inc_en low it holds.
- R9: done_evt is high for one cycle, in the cycle that follows the last host word. busy_set and host_irq copy done_evt when the busy-on-done and auto interrupt enables are set.
- R10: When a host word and a local access fall in the same cycle, the host word gets the port. In the next cycle with no host word, the local access is issued with the disk address and write flag that were captured at the collision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| size_sel | input | 3 | Wrap size code |
| auto_inc_en | input | 1 | Disk pointer advances after each local access |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 6 | Control word write data |
| ctl_rdata | output | 6 | Control word readback |
| host_ld | input | 1 | Load host pointer |
| host_ld_val | input | 15 | Host pointer load value |
| disk_ld | input | 1 | Load disk pointer |
| disk_ld_val | input | 15 | Disk pointer load value |
| stop_ld | input | 1 | Load stop pointer |
| stop_ld_val | input | 15 | Stop pointer load value |
| host_xfer | input | 1 | Host moves one word this cycle |
| lcl_acc | input | 1 | Local port access this cycle |
| lcl_wr | input | 1 | Local access is a write |
| ram_addr | output | 15 | RAM word address |
| ram_en | output | 1 | RAM enable |
| ram_we | output | 1 | RAM write strobe |
| ram_host_sel | output | 1 | Port owned by the host this cycle |
| xfer_req | output | 1 | Host transfer request |
| done_evt | output | 1 | Burst completion pulse |
| busy_set | output | 1 | Set-busy pulse on completion |
| host_irq | output | 1 | Host interrupt pulse on completion |
| host_ptr | output | 15 | Host pointer |
| disk_ptr | output | 15 | Disk pointer |
| stop_ptr | output | 15 | Stop pointer |

## Verification
The assertions rely on several assumptions about the inputs. size_sel stays fixed during a burst. No control write or stop-pointer load falls in the cycle of a burst's last word. A second local access is never issued while a deferred one is still waiting for the port. The stimulus keeps to all three: it changes the size and loads pointers only before it writes the start bit, it writes the control word only when no host word is pending, and after each collision it drops host_xfer for one cycle so the deferred access can be issued.

// File: rtl/sbuf_pkg.sv
// Shared constants for the circular buffer pointer manager.
// Assumes the control word layout below is decoded by neighbouring logic.
package sbuf_pkg;
    localparam int SEL_W   = 3;
    localparam int CTL_W   = 6;
    localparam int CB_START = 0;
    localparam int CB_DONE  = 1;
    localparam int CB_DIR   = 2;
    localparam int CB_OFF   = 3;
    localparam int CB_IRQ   = 4;
    localparam int CB_BUSY  = 5;
    localparam logic [CTL_W-1:0] CTL_RST = 6'h08;

    // Number of address bits removed from the full size for a size code.
    function automatic logic [SEL_W-1:0] size_shrink(input logic [SEL_W-1:0] sel);
        return (sel < 3'd2) ? 3'd0 : sel - 3'd1;
    endfunction
endpackage

// File: rtl/sbuf_size_dec.sv
// Turns the size code into a wrap mask over the pointer width.
// Assumes ADDR_W >= 7 so the smallest size keeps at least one bit.
module sbuf_size_dec
    import sbuf_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic [SEL_W-1:0]  size_sel,
    output logic [ADDR_W-1:0] wrap_mask
);
    logic [SEL_W-1:0] shrink;

    // Purpose: how many top bits the selected size drops.
    always_comb shrink = size_shrink(size_sel);

    for (genvar g = 0; g < ADDR_W; g++) begin : g_mask
        assign wrap_mask[g] = (32'(shrink) + 32'(g)) < 32'(ADDR_W);
    end
endmodule

// File: rtl/sbuf_host_eng.sv
// Host burst engine: control word, host and stop pointers, completion.
// Assumes no control write lands in the cycle of a burst's last word.
module sbuf_host_eng
    import sbuf_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter logic [ADDR_W-1:0] STOP_RST = 'h00FF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] wrap_mask,
    input  logic              ctl_wr,
    input  logic [CTL_W-1:0]  ctl_wdata,
    output logic [CTL_W-1:0]  ctl_q,
    input  logic              host_ld,
    input  logic [ADDR_W-1:0] host_ld_val,
    input  logic              stop_ld,
    input  logic [ADDR_W-1:0] stop_ld_val,
    input  logic              host_xfer,
    output logic              hx,
    output logic [ADDR_W-1:0] host_ptr,
    output logic [ADDR_W-1:0] stop_ptr,
    output logic              xfer_req,
    output logic              done_evt,
    output logic              busy_set,
    output logic              host_irq
);
    logic [CTL_W-1:0]  ctl_r;
    logic [ADDR_W-1:0] host_nxt;
    logic              hit;

    // Purpose: qualify a host word and find the burst's last word.
    always_comb begin
        hx       = host_xfer & ctl_r[CB_START] & ~ctl_r[CB_OFF];
        host_nxt = ADDR_W'(host_ptr + 1'b1) & wrap_mask;
        hit      = hx & (host_nxt == stop_ptr);
    end

    // Purpose: control word with start/done sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_r <= CTL_RST;
        end else if (ctl_wr) begin
            ctl_r[CB_BUSY]  <= ctl_wdata[CB_BUSY];
            ctl_r[CB_IRQ]   <= ctl_wdata[CB_IRQ];
            ctl_r[CB_OFF]   <= ctl_wdata[CB_OFF];
            ctl_r[CB_DIR]   <= ctl_wdata[CB_DIR];
            ctl_r[CB_START] <= ctl_wdata[CB_START];
            if (ctl_wdata[CB_START]) ctl_r[CB_DONE] <= 1'b0;
        end else if (hit) begin
            ctl_r[CB_START] <= 1'b0;
            ctl_r[CB_DONE]  <= 1'b1;
        end
    end

    // Purpose: host pointer load or advance.
    always_ff @(posedge clk) begin
        if (!rst_n)       host_ptr <= '0;
        else if (host_ld) host_ptr <= host_ld_val & wrap_mask;
        else if (hx)      host_ptr <= host_nxt;
    end

    // Purpose: stop pointer load.
    always_ff @(posedge clk) begin
        if (!rst_n)       stop_ptr <= STOP_RST;
        else if (stop_ld) stop_ptr <= stop_ld_val & wrap_mask;
    end

    // Purpose: one-cycle completion event.
    always_ff @(posedge clk) begin
        if (!rst_n) done_evt <= 1'b0;
        else        done_evt <= hit;
    end

    // Purpose: outward status and completion side effects.
    always_comb begin
        ctl_q    = ctl_r;
        xfer_req = ctl_r[CB_START] & ~ctl_r[CB_DONE];
        busy_set = done_evt & ctl_r[CB_BUSY];
        host_irq = done_evt & ctl_r[CB_IRQ];
    end
endmodule

// File: rtl/sbuf_lcl_port.sv
// Local access port: disk pointer, auto increment, one deferred slot.
// Assumes no new local access arrives while a deferred one is waiting.
module sbuf_lcl_port #(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] wrap_mask,
    input  logic              auto_inc_en,
    input  logic              ram_off,
    input  logic              hx,
    input  logic              disk_ld,
    input  logic [ADDR_W-1:0] disk_ld_val,
    input  logic              lcl_acc,
    input  logic              lcl_wr,
    output logic [ADDR_W-1:0] disk_ptr,
    output logic              lcl_go,
    output logic [ADDR_W-1:0] lcl_addr,
    output logic              lcl_we
);
    logic              acc_ok;
    logic              pend;
    logic [ADDR_W-1:0] pend_addr;
    logic              pend_we;

    // Purpose: decide what the local side asks of the port now.
    always_comb begin
        acc_ok   = lcl_acc & ~ram_off;
        lcl_go   = ~hx & (pend | acc_ok);
        lcl_addr = pend ? pend_addr : disk_ptr;
        lcl_we   = pend ? pend_we : lcl_wr;
    end

    // Purpose: disk pointer load or auto advance on accepted access.
    always_ff @(posedge clk) begin
        if (!rst_n)                    disk_ptr <= '0;
        else if (disk_ld)              disk_ptr <= disk_ld_val & wrap_mask;
        else if (acc_ok & auto_inc_en) disk_ptr <= ADDR_W'(disk_ptr + 1'b1) & wrap_mask;
    end

    // Purpose: hold a local access that lost the port to a host word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend      <= 1'b0;
            pend_addr <= '0;
            pend_we   <= 1'b0;
        end else if (pend) begin
            if (!hx) pend <= 1'b0;
        end else if (acc_ok & hx) begin
            pend      <= 1'b1;
            pend_addr <= disk_ptr;
            pend_we   <= lcl_wr;
        end
    end
endmodule

// File: rtl/sbuf_port_mux.sv
// Shared RAM port: host words win, local accesses fill the rest.
// Assumes its inputs are already qualified by burst state.
module sbuf_port_mux #(
    parameter int ADDR_W = 15
) (
    input  logic              ram_off,
    input  logic              hx,
    input  logic [ADDR_W-1:0] host_ptr,
    input  logic              dir,
    input  logic              lcl_go,
    input  logic [ADDR_W-1:0] lcl_addr,
    input  logic              lcl_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_en,
    output logic              ram_we,
    output logic              ram_host_sel
);
    // Purpose: pick the owner of the port and gate with the RAM disable.
    always_comb begin
        ram_host_sel = hx;
        ram_en       = ~ram_off & (hx | lcl_go);
        ram_addr     = hx ? host_ptr : lcl_addr;
        ram_we       = ram_en & (hx ? dir : lcl_we);
    end
endmodule

// File: rtl/sbuf_ptr_mgr.sv
// Top: circular buffer pointer manager for a host/local shared RAM.
// Assumes size_sel is held steady while a burst runs.
module sbuf_ptr_mgr
    import sbuf_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        size_sel,
    input  logic              auto_inc_en,
    input  logic              ctl_wr,
    input  logic [5:0]        ctl_wdata,
    output logic [5:0]        ctl_rdata,
    input  logic              host_ld,
    input  logic [ADDR_W-1:0] host_ld_val,
    input  logic              disk_ld,
    input  logic [ADDR_W-1:0] disk_ld_val,
    input  logic              stop_ld,
    input  logic [ADDR_W-1:0] stop_ld_val,
    input  logic              host_xfer,
    input  logic              lcl_acc,
    input  logic              lcl_wr,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_en,
    output logic              ram_we,
    output logic              ram_host_sel,
    output logic              xfer_req,
    output logic              done_evt,
    output logic              busy_set,
    output logic              host_irq,
    output logic [ADDR_W-1:0] host_ptr,
    output logic [ADDR_W-1:0] disk_ptr,
    output logic [ADDR_W-1:0] stop_ptr
);
    logic [ADDR_W-1:0] wrap_mask;
    logic              hx;
    logic              lcl_go;
    logic [ADDR_W-1:0] lcl_addr;
    logic              lcl_we;
    logic [CTL_W-1:0]  ctl_q;

    sbuf_size_dec #(.ADDR_W(ADDR_W)) u_dec (
        .size_sel (size_sel),
        .wrap_mask(wrap_mask)
    );

    sbuf_host_eng #(.ADDR_W(ADDR_W)) u_host (
        .clk        (clk),
        .rst_n      (rst_n),
        .wrap_mask  (wrap_mask),
        .ctl_wr     (ctl_wr),
        .ctl_wdata  (ctl_wdata),
        .ctl_q      (ctl_q),
        .host_ld    (host_ld),
        .host_ld_val(host_ld_val),
        .stop_ld    (stop_ld),
        .stop_ld_val(stop_ld_val),
        .host_xfer  (host_xfer),
        .hx         (hx),
        .host_ptr   (host_ptr),
        .stop_ptr   (stop_ptr),
        .xfer_req   (xfer_req),
        .done_evt   (done_evt),
        .busy_set   (busy_set),
        .host_irq   (host_irq)
    );

    sbuf_lcl_port #(.ADDR_W(ADDR_W)) u_lcl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wrap_mask  (wrap_mask),
        .auto_inc_en(auto_inc_en),
        .ram_off    (ctl_q[CB_OFF]),
        .hx         (hx),
        .disk_ld    (disk_ld),
        .disk_ld_val(disk_ld_val),
        .lcl_acc    (lcl_acc),
        .lcl_wr     (lcl_wr),
        .disk_ptr   (disk_ptr),
        .lcl_go     (lcl_go),
        .lcl_addr   (lcl_addr),
        .lcl_we     (lcl_we)
    );

    sbuf_port_mux #(.ADDR_W(ADDR_W)) u_mux (
        .ram_off     (ctl_q[CB_OFF]),
        .hx          (hx),
        .host_ptr    (host_ptr),
        .dir         (ctl_q[CB_DIR]),
        .lcl_go      (lcl_go),
        .lcl_addr    (lcl_addr),
        .lcl_we      (lcl_we),
        .ram_addr    (ram_addr),
        .ram_en      (ram_en),
        .ram_we      (ram_we),
        .ram_host_sel(ram_host_sel)
    );

    assign ctl_rdata = ctl_q;
endmodule

// File: rtl/sbuf_ptr_mgr_chk.sv
// Property checker for the pointer manager, bound to the top module.
// Assumes the input rules listed in the brief's verification section.
module sbuf_ptr_mgr_chk #(
    parameter int ADDR_W = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hx,
    input logic              host_ld,
    input logic              disk_ld,
    input logic              lcl_acc,
    input logic              auto_inc_en,
    input logic [ADDR_W-1:0] wrap_mask,
    input logic [5:0]        ctl_rdata,
    input logic              ram_en,
    input logic              ram_host_sel,
    input logic [ADDR_W-1:0] ram_addr,
    input logic [ADDR_W-1:0] host_ptr,
    input logic [ADDR_W-1:0] disk_ptr,
    input logic [ADDR_W-1:0] stop_ptr,
    input logic              xfer_req,
    input logic              done_evt
);
    assert_ram_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rdata[3] |-> !ram_en);

    assert_host_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hx && !host_ld) |=> host_ptr == (ADDR_W'($past(host_ptr) + 1'b1) & $past(wrap_mask)));

    assert_host_owns_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hx |-> (ram_en && ram_host_sel && ram_addr == host_ptr));

    assert_done_at_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_rdata[1]) |-> host_ptr == stop_ptr);

    assert_req_state_R6: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req |-> (ctl_rdata[0] && !ctl_rdata[1]));

    assert_disk_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (lcl_acc && auto_inc_en && !ctl_rdata[3] && !disk_ld)
        |=> disk_ptr == (ADDR_W'($past(disk_ptr) + 1'b1) & $past(wrap_mask)));

    assert_evt_state_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_evt |-> (!xfer_req && ctl_rdata[1]));

    assert_deferred_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(hx && lcl_acc && !ctl_rdata[3]) && !hx && !ctl_rdata[3])
        |-> (ram_en && !ram_host_sel));
endmodule

bind sbuf_ptr_mgr sbuf_ptr_mgr_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hx          (hx),
    .host_ld     (host_ld),
    .disk_ld     (disk_ld),
    .lcl_acc     (lcl_acc),
    .auto_inc_en (auto_inc_en),
    .wrap_mask   (wrap_mask),
    .ctl_rdata   (ctl_rdata),
    .ram_en      (ram_en),
    .ram_host_sel(ram_host_sel),
    .ram_addr    (ram_addr),
    .host_ptr    (host_ptr),
    .disk_ptr    (disk_ptr),
    .stop_ptr    (stop_ptr),
    .xfer_req    (xfer_req),
    .done_evt    (done_evt)
);

// File: tb/sbuf_ptr_mgr_bench.sv
module sbuf_ptr_mgr_bench;
    localparam int AW = 15;

    typedef struct packed {
        logic [2:0]    sel;
        logic [AW-1:0] first;
        logic [AW-1:0] stop;
        logic          dir;
        logic          busy;
        logic          irq;
        logic [15:0]   words;
    } vec_t;

    localparam vec_t VECS [0:7] = '{
        '{3'd7, 15'h01F0, 15'h0010, 1'b0, 1'b1, 1'b0, 16'd32},
        '{3'd6, 15'h03FE, 15'h0002, 1'b1, 1'b0, 1'b1, 16'd4},
        '{3'd0, 15'h0000, 15'h0005, 1'b0, 1'b1, 1'b1, 16'd5},
        '{3'd5, 15'h0100, 15'h0100, 1'b1, 1'b0, 1'b0, 16'd2048},
        '{3'd2, 15'h3FFC, 15'h0001, 1'b0, 1'b0, 1'b1, 16'd5},
        '{3'd1, 15'h7FFF, 15'h0000, 1'b1, 1'b1, 1'b0, 16'd1},
        '{3'd4, 15'h0FF0, 15'h0FF3, 1'b0, 1'b0, 1'b0, 16'd3},
        '{3'd3, 15'h1FFF, 15'h0002, 1'b1, 1'b1, 1'b1, 16'd3}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    size_sel = '0;
    logic          auto_inc_en = 1'b0;
    logic          ctl_wr = 1'b0;
    logic [5:0]    ctl_wdata = '0;
    logic [5:0]    ctl_rdata;
    logic          host_ld = 1'b0;
    logic [AW-1:0] host_ld_val = '0;
    logic          disk_ld = 1'b0;
    logic [AW-1:0] disk_ld_val = '0;
    logic          stop_ld = 1'b0;
    logic [AW-1:0] stop_ld_val = '0;
    logic          host_xfer = 1'b0;
    logic          lcl_acc = 1'b0;
    logic          lcl_wr = 1'b0;
    logic [AW-1:0] ram_addr;
    logic          ram_en, ram_we, ram_host_sel;
    logic          xfer_req, done_evt, busy_set, host_irq;
    logic [AW-1:0] host_ptr, disk_ptr, stop_ptr;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    sbuf_ptr_mgr #(.ADDR_W(AW)) u_sbuf_ptr_mgr (
        .clk(clk), .rst_n(rst_n), .size_sel(size_sel), .auto_inc_en(auto_inc_en),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .host_ld(host_ld), .host_ld_val(host_ld_val),
        .disk_ld(disk_ld), .disk_ld_val(disk_ld_val),
        .stop_ld(stop_ld), .stop_ld_val(stop_ld_val),
        .host_xfer(host_xfer), .lcl_acc(lcl_acc), .lcl_wr(lcl_wr),
        .ram_addr(ram_addr), .ram_en(ram_en), .ram_we(ram_we), .ram_host_sel(ram_host_sel),
        .xfer_req(xfer_req), .done_evt(done_evt), .busy_set(busy_set), .host_irq(host_irq),
        .host_ptr(host_ptr), .disk_ptr(disk_ptr), .stop_ptr(stop_ptr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic ctl_write(input logic [5:0] v);
        ctl_wr = 1'b1;
        ctl_wdata = v;
        tick();
        ctl_wr = 1'b0;
    endtask

    task automatic run_vec(input vec_t v);
        int n;
        size_sel = v.sel;
        host_ld = 1'b1; host_ld_val = v.first;
        stop_ld = 1'b1; stop_ld_val = v.stop;
        tick();
        host_ld = 1'b0; stop_ld = 1'b0;
        ctl_write({v.busy, v.irq, 1'b0, v.dir, 1'b0, 1'b1});
        chk("R6 req after start", 32'(xfer_req), 32'd1);
        host_xfer = 1'b1;
        #1;
        chk("R4 first word addr", 32'(ram_addr), 32'(v.first));
        chk("R4 host owns port", 32'(ram_host_sel), 32'd1);
        chk("R3 write strobe follows dir", 32'(ram_we), 32'(v.dir));
        n = 0;
        while (xfer_req && n < 5000) begin
            tick();
            n++;
        end
        host_xfer = 1'b0;
        chk("R5 word count", 32'(n), 32'(v.words));
        chk("R5 host ptr at stop", 32'(host_ptr), 32'(v.stop));
        chk("R5 done set start clear", 32'(ctl_rdata[1:0]), 32'd2);
        chk("R9 done pulse", 32'(done_evt), 32'd1);
        chk("R9 busy set", 32'(busy_set), 32'(v.busy));
        chk("R9 host irq", 32'(host_irq), 32'(v.irq));
        tick();
        chk("R9 pulse single cycle", 32'(done_evt), 32'd0);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 host ptr", 32'(host_ptr), 32'h0);
        chk("R1 disk ptr", 32'(disk_ptr), 32'h0);
        chk("R1 stop ptr", 32'(stop_ptr), 32'h00FF);
        chk("R1 control", 32'(ctl_rdata), 32'h08);
        chk("R1 req low", 32'(xfer_req), 32'd0);
        chk("R1 ram idle", 32'(ram_en), 32'd0);
        @(negedge clk);

        // R7 RAM disabled: strobes ignored
        ctl_write(6'h09);
        chk("R6 req with ram off", 32'(xfer_req), 32'd1);
        host_xfer = 1'b1; lcl_acc = 1'b1; auto_inc_en = 1'b1;
        #1;
        chk("R7 ram_en low", 32'(ram_en), 32'd0);
        tick();
        host_xfer = 1'b0; lcl_acc = 1'b0;
        chk("R7 host ptr holds", 32'(host_ptr), 32'h0);
        chk("R7 disk ptr holds", 32'(disk_ptr), 32'h0);
        ctl_write(6'h08);
        chk("R6 abort drops req", 32'(xfer_req), 32'd0);
        chk("R6 abort leaves done clear", 32'(ctl_rdata), 32'h08);

        // Vector table: bursts across sizes, wraps and directions
        for (int i = 0; i < 8; i++) run_vec(VECS[i]);

        // R8 local port with auto increment
        size_sel = 3'd0;
        disk_ld = 1'b1; disk_ld_val = 15'h0010;
        tick();
        disk_ld = 1'b0;
        auto_inc_en = 1'b1; lcl_acc = 1'b1; lcl_wr = 1'b1;
        #1;
        chk("R8 local addr", 32'(ram_addr), 32'h10);
        chk("R8 local we", 32'(ram_we), 32'd1);
        chk("R8 local en", 32'(ram_en & ~ram_host_sel), 32'd1);
        tick();
        chk("R8 disk advanced", 32'(disk_ptr), 32'h11);
        lcl_wr = 1'b0;
        #1;
        chk("R8 local read we", 32'(ram_we), 32'd0);
        tick();
        lcl_acc = 1'b0;
        chk("R8 disk advanced twice", 32'(disk_ptr), 32'h12);
        auto_inc_en = 1'b0; lcl_acc = 1'b1;
        tick();
        lcl_acc = 1'b0;
        chk("R8 no advance without auto", 32'(disk_ptr), 32'h12);

        // R2 wrap of disk pointer and masked load
        size_sel = 3'd7;
        disk_ld = 1'b1; disk_ld_val = 15'h01FF;
        host_ld = 1'b1; host_ld_val = 15'h7ABC;
        tick();
        disk_ld = 1'b0; host_ld = 1'b0;
        chk("R2 load masked", 32'(host_ptr), 32'h00BC);
        auto_inc_en = 1'b1; lcl_acc = 1'b1;
        tick();
        lcl_acc = 1'b0;
        chk("R2 disk wraps at 512", 32'(disk_ptr), 32'h0);

        // R10 collision: host first, local deferred
        size_sel = 3'd0;
        host_ld = 1'b1; host_ld_val = 15'h0040;
        stop_ld = 1'b1; stop_ld_val = 15'h0050;
        disk_ld = 1'b1; disk_ld_val = 15'h0200;
        tick();
        host_ld = 1'b0; stop_ld = 1'b0; disk_ld = 1'b0;
        ctl_write(6'h05);
        host_xfer = 1'b1; lcl_acc = 1'b1; lcl_wr = 1'b0;
        #1;
        chk("R10 host takes port", 32'(ram_host_sel), 32'd1);
        chk("R10 host addr", 32'(ram_addr), 32'h40);
        chk("R3 host write", 32'(ram_we), 32'd1);
        tick();
        host_xfer = 1'b0; lcl_acc = 1'b0;
        #1;
        chk("R10 deferred local issued", 32'(ram_en & ~ram_host_sel), 32'd1);
        chk("R10 deferred addr", 32'(ram_addr), 32'h200);
        chk("R10 deferred we", 32'(ram_we), 32'd0);
        chk("R10 disk ptr advanced", 32'(disk_ptr), 32'h201);
        chk("R4 host ptr advanced", 32'(host_ptr), 32'h41);
        tick();
        chk("R10 port idle after", 32'(ram_en), 32'd0);
        ctl_write(6'h00);
        chk("R6 abort control", 32'(ctl_rdata), 32'h00);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule